// File: doc/BRIEF.md
# Edge-Coded Multi-Line Signal Link

This block carries a small set of single-bit logic lines between two sides, A and B, over an internal command channel instead of wiring each level straight through. A parameter fixes the direction of every line. On the sending side, each accepted input transition becomes a command that carries the line index and the new level. The receiving side keeps one latch per line and changes it only when a command for that line arrives. Each direction has its own command channel, which carries at most one command per clock.

Transitions always win the channel. A background timer runs with a fixed period. At the end of each period it queues a resend of the present level for every line that saw no transition during that period. These resends are served round-robin. As a result, a receiver latch that has been disturbed converges back to the input within at most two periods.

Both sides have an enable. Dropping an enable stops that side from driving its outputs and freezes its sampled inputs. Raising it again triggers a resend of every line. After reset there is a hold-off interval, during which nothing is driven and nothing is sent. When the hold-off ends, every line is resent. An input pulse narrower than a set number of cycles is filtered out.

Top module: `elink_top`

## Requirements
- R1: After reset, when a line's input changes and then stays stable, the output on the opposite side takes the new level within MIN_PULSE + NUM_LINES + 6 cycles, and the link delivers both rising and falling changes.
- R2: A receiver latch that has been corrupted while its input was idle is restored to the input level within 2*REFRESH_CYC + 20 cycles, through the periodic resend.
- R3: Pending transition commands take priority over resends. When several lines change in the same cycle, all of them reach their outputs within the R1 bound.
- R4: After reset every receiver latch holds 0, and no output is driven until the first command for that line has arrived.
- R5: For HOLDOFF_CYC cycles after reset release, every output enable is 0. When the hold-off ends, every output reaches its input's level without any further input activity.
- R6: While a side's enable is 0, every output enable on that side is 0. Input changes on that side during that time never reach the other side, including across refresh periods.
- R7: When an enable returns to 1, every output on both sides reflects the present input level within MIN_PULSE + NUM_LINES + 10 cycles.
- R8: Bit i of DIR_AB set to 1 means line i goes from A to B, and set to 0 means it goes from B to A. The output enable of a line is never 1 on that line's sending side.
- R9: An input level held for fewer than MIN_PULSE cycles never reaches the output. A level held for MIN_PULSE or more cycles does reach it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset (supply good), released synchronously |
| a_en | input | 1 | Side A enable; 0 tri-states A outputs and freezes A inputs |
| a_pin_in | input | NUM_LINES | Side A input levels (used where DIR_AB bit is 1) |
| a_pin_out | output | NUM_LINES | Side A output levels (meaningful where DIR_AB bit is 0) |
| a_pin_oe | output | NUM_LINES | Side A output drive enables |
| b_en | input | 1 | Side B enable; 0 tri-states B outputs and freezes B inputs |
| b_pin_in | input | NUM_LINES | Side B input levels (used where DIR_AB bit is 0) |
| b_pin_out | output | NUM_LINES | Side B output levels (meaningful where DIR_AB bit is 1) |
| b_pin_oe | output | NUM_LINES | Side B output drive enables |

## Verification
Single-line toggles in both directions exercise the edge path and show that rising and falling changes are both delivered. Toggling several lines in the same cycle exercises arbitration: a lost or starved edge shows up as a late output. Pulses just below and well above the minimum width tell the glitch filter apart from a plain pass-through. Enable drops held across refresh periods, re-enables, and a command forced onto the channel separate the freeze, resync and periodic-repair paths from each other.

// File: rtl/elink_pkg.sv
package elink_pkg;

  // Lowest set index of req among the first n bits; n when none is set.
  function automatic int pick_low(input logic [31:0] req, input int n);
    int r;
    r = n;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && req[i]) r = i;
    end
    return r;
  endfunction

  // First set index of req at or after start, wrapping within n bits.
  function automatic int pick_rr(input logic [31:0] req, input int start, input int n);
    int r;
    r = n;
    for (int k = 31; k >= 0; k--) begin
      if (k < n) begin
        int j;
        j = (start + k) % n;
        if (req[j]) r = j;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/elink_filter.sv
module elink_filter #(
  parameter int MIN_PULSE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic chg
);
  localparam int CW = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    chg   = 1'b0;
    if (din != lvl_q) begin
      if (cnt_q == CW'(MIN_PULSE - 1)) begin
        lvl_d = din;
        cnt_d = '0;
        chg   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl = lvl_q;

  generate
    if (MIN_PULSE > 1) begin : g_chk
      // R9: a new level is accepted only after the input held it for more than one cycle
      a_r9_stable_before_accept: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (din == $past(din)));
    end
  endgenerate

endmodule

// File: rtl/elink_enc.sv
module elink_enc
  import elink_pkg::*;
#(
  parameter int             NUM_LINES   = 5,
  parameter logic [NUM_LINES-1:0] LINE_MASK = '1,
  parameter int             REFRESH_CYC = 250000,
  parameter int             MIN_PULSE   = 2,
  localparam int            IW          = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 resync,
  input  logic [NUM_LINES-1:0] lvl_in,
  output logic                 cmd_vld,
  output logic [IW-1:0]        cmd_idx,
  output logic                 cmd_val
);
  localparam int TW = (REFRESH_CYC < 2) ? 1 : $clog2(REFRESH_CYC);

  logic [NUM_LINES-1:0] flt, chg;
  logic [NUM_LINES-1:0] edge_q, edge_d, ref_q, ref_d, act_q, act_d, gnt_oh;
  logic [TW-1:0]        tmr_q, tmr_d;
  logic [IW-1:0]        ptr_q, ptr_d;
  logic                 tick, use_edge;
  int                   g_edge, g_ref;

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (LINE_MASK[i]) begin : g_on
        elink_filter #(.MIN_PULSE(MIN_PULSE)) u_flt (
          .clk(clk), .rst_n(rst_n), .din(lvl_in[i]), .lvl(flt[i]), .chg(chg[i])
        );
      end else begin : g_off
        assign flt[i] = 1'b0;
        assign chg[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    g_edge   = pick_low(32'(edge_q), NUM_LINES);
    g_ref    = pick_rr(32'(ref_q), int'(ptr_q), NUM_LINES);
    use_edge = |edge_q;
    cmd_vld  = run && (use_edge || (|ref_q));
    cmd_idx  = use_edge ? IW'(g_edge) : IW'(g_ref);
    cmd_val  = flt[cmd_idx];
    gnt_oh   = cmd_vld ? (NUM_LINES'(1) << cmd_idx) : '0;
    tick     = run && (tmr_q == TW'(REFRESH_CYC - 1));
    tmr_d    = (!run || tick) ? '0 : tmr_q + 1'b1;
    edge_d   = (edge_q & ~gnt_oh) | chg;
    ref_d    = (ref_q & ~gnt_oh)
             | (tick ? (LINE_MASK & ~(act_q | chg)) : '0)
             | (resync ? LINE_MASK : '0);
    act_d    = tick ? '0 : (act_q | chg);
    ptr_d    = ptr_q;
    if (cmd_vld && !use_edge) begin
      ptr_d = (cmd_idx == IW'(NUM_LINES - 1)) ? '0 : cmd_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      ref_q  <= '0;
      act_q  <= '0;
      tmr_q  <= '0;
      ptr_q  <= '0;
    end else begin
      edge_q <= edge_d;
      ref_q  <= ref_d;
      act_q  <= act_d;
      tmr_q  <= tmr_d;
      ptr_q  <= ptr_d;
    end
  end

  // R8: only lines owned by this direction are ever sent
  a_r8_masked_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> LINE_MASK[cmd_idx]);

  // R3: with no new edges, pending edges drain by one every cycle while running
  a_r3_edge_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (|edge_q) && !(|chg)) |=> ($countones(edge_q) < $countones($past(edge_q))));

endmodule

// File: rtl/elink_dec.sv
module elink_dec #(
  parameter int   NUM_LINES = 5,
  parameter logic INIT_LVL  = 1'b0,
  localparam int  IW        = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_vld,
  input  logic [IW-1:0]        cmd_idx,
  input  logic                 cmd_val,
  output logic [NUM_LINES-1:0] lvl_out,
  output logic [NUM_LINES-1:0] seen
);
  logic [NUM_LINES-1:0] lvl_q, lvl_d, seen_q, seen_d;

  always_comb begin
    lvl_d  = lvl_q;
    seen_d = seen_q;
    if (cmd_vld) begin
      lvl_d[cmd_idx]  = cmd_val;
      seen_d[cmd_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= {NUM_LINES{INIT_LVL}};
      seen_q <= '0;
    end else begin
      lvl_q  <= lvl_d;
      seen_q <= seen_d;
    end
  end

  assign lvl_out = lvl_q;
  assign seen    = seen_q;

  // R1: a received command lands in the addressed latch on the next cycle
  a_r1_latch_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> (lvl_q[$past(cmd_idx)] == $past(cmd_val)) && seen_q[$past(cmd_idx)]);

endmodule

// File: rtl/elink_top.sv
module elink_top #(
  parameter int                   NUM_LINES   = 5,
  parameter logic [NUM_LINES-1:0] DIR_AB      = 5'b00111,
  parameter int                   REFRESH_CYC = 250000,
  parameter int                   HOLDOFF_CYC = 1500000,
  parameter int                   MIN_PULSE   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 a_en,
  input  logic [NUM_LINES-1:0] a_pin_in,
  output logic [NUM_LINES-1:0] a_pin_out,
  output logic [NUM_LINES-1:0] a_pin_oe,
  input  logic                 b_en,
  input  logic [NUM_LINES-1:0] b_pin_in,
  output logic [NUM_LINES-1:0] b_pin_out,
  output logic [NUM_LINES-1:0] b_pin_oe
);
  localparam int IW = (NUM_LINES < 2) ? 1 : $clog2(NUM_LINES);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);

  logic [1:0]           rsync_q;
  logic                 rst_ni;
  logic [HW-1:0]        hcnt_q, hcnt_d;
  logic                 run, run_q1, en_a_q, en_b_q, resync;
  logic [NUM_LINES-1:0] a_smp_q, a_smp_d, b_smp_q, b_smp_d;
  logic                 ab_vld, ab_val, ba_vld, ba_val;
  logic [IW-1:0]        ab_idx, ba_idx;
  logic [NUM_LINES-1:0] ab_lvl, ab_seen, ba_lvl, ba_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  always_comb begin
    run     = (hcnt_q == HW'(HOLDOFF_CYC));
    hcnt_d  = run ? hcnt_q : hcnt_q + 1'b1;
    resync  = run && (!run_q1 || (a_en && !en_a_q) || (b_en && !en_b_q));
    a_smp_d = (run && a_en) ? a_pin_in : a_smp_q;
    b_smp_d = (run && b_en) ? b_pin_in : b_smp_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      run_q1  <= 1'b0;
      en_a_q  <= 1'b0;
      en_b_q  <= 1'b0;
      a_smp_q <= '0;
      b_smp_q <= '0;
    end else begin
      hcnt_q  <= hcnt_d;
      run_q1  <= run;
      en_a_q  <= a_en;
      en_b_q  <= b_en;
      a_smp_q <= a_smp_d;
      b_smp_q <= b_smp_d;
    end
  end

  elink_enc #(.NUM_LINES(NUM_LINES), .LINE_MASK(DIR_AB), .REFRESH_CYC(REFRESH_CYC),
              .MIN_PULSE(MIN_PULSE)) u_enc_ab (
    .clk(clk), .rst_n(rst_ni), .run(run), .resync(resync), .lvl_in(a_smp_q),
    .cmd_vld(ab_vld), .cmd_idx(ab_idx), .cmd_val(ab_val));

  elink_dec #(.NUM_LINES(NUM_LINES)) u_dec_ab (
    .clk(clk), .rst_n(rst_ni), .cmd_vld(ab_vld), .cmd_idx(ab_idx), .cmd_val(ab_val),
    .lvl_out(ab_lvl), .seen(ab_seen));

  elink_enc #(.NUM_LINES(NUM_LINES), .LINE_MASK(~DIR_AB), .REFRESH_CYC(REFRESH_CYC),
              .MIN_PULSE(MIN_PULSE)) u_enc_ba (
    .clk(clk), .rst_n(rst_ni), .run(run), .resync(resync), .lvl_in(b_smp_q),
    .cmd_vld(ba_vld), .cmd_idx(ba_idx), .cmd_val(ba_val));

  elink_dec #(.NUM_LINES(NUM_LINES)) u_dec_ba (
    .clk(clk), .rst_n(rst_ni), .cmd_vld(ba_vld), .cmd_idx(ba_idx), .cmd_val(ba_val),
    .lvl_out(ba_lvl), .seen(ba_seen));

  assign b_pin_out = ab_lvl & DIR_AB;
  assign b_pin_oe  = {NUM_LINES{run && b_en}} & DIR_AB & ab_seen;
  assign a_pin_out = ba_lvl & ~DIR_AB;
  assign a_pin_oe  = {NUM_LINES{run && a_en}} & ~DIR_AB & ba_seen;

  // R5: nothing is driven on either side during the hold-off
  a_r5_holdoff_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |-> (a_pin_oe == '0) && (b_pin_oe == '0));

  // R6: a disabled side keeps its sampled inputs frozen
  a_r6_frozen_inputs: assert property (@(posedge clk) disable iff (!rst_ni)
    !a_en |=> $stable(a_smp_q));

endmodule

// File: tb/elink_top_bench.sv
module elink_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 5;
  localparam logic [N-1:0] DIR = 5'b00111;
  localparam int REFRESH    = 64;
  localparam int HOLDOFF    = 40;
  localparam int MINP       = 4;
  localparam int EDGE_BND   = MINP + N + 6;
  localparam int REEN_BND   = MINP + N + 10;
  localparam int REC_BND    = 2 * REFRESH + 20;

  logic clk = 1'b0;
  logic rst_n, a_en, b_en;
  logic [N-1:0] a_pin_in, b_pin_in, a_pin_out, a_pin_oe, b_pin_out, b_pin_oe;

  elink_top #(.NUM_LINES(N), .DIR_AB(DIR), .REFRESH_CYC(REFRESH),
              .HOLDOFF_CYC(HOLDOFF), .MIN_PULSE(MINP)) u_elink_top (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .a_pin_in(a_pin_in), .a_pin_out(a_pin_out),
    .a_pin_oe(a_pin_oe), .b_en(b_en), .b_pin_in(b_pin_in), .b_pin_out(b_pin_out),
    .b_pin_oe(b_pin_oe));

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int    side;   // 0: observed on A, 1: observed on B
    int    line;
    logic  val;
    int    bound;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   busy = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input int side, input int line, input logic val,
                            input int bound, input string tag);
    exp_t e;
    e.side = side; e.line = line; e.val = val; e.bound = bound; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic settle();
    do @(negedge clk); while (exp_q.size() != 0 || busy);
  endtask

  // Monitor: pops expectations and waits for the driven output to match.
  initial begin
    forever begin
      exp_t e;
      bit   hit;
      int   got;
      @(negedge clk);
      if (exp_q.size() != 0) begin
        busy = 1'b1;
        e = exp_q.pop_front();
        hit = 1'b0;
        for (int c = 0; c < e.bound && !hit; c++) begin
          if (e.side == 0) hit = a_pin_oe[e.line] && (a_pin_out[e.line] == e.val);
          else             hit = b_pin_oe[e.line] && (b_pin_out[e.line] == e.val);
          if (!hit) @(negedge clk);
        end
        got = (e.side == 0) ? int'({a_pin_oe[e.line], a_pin_out[e.line]})
                            : int'({b_pin_oe[e.line], b_pin_out[e.line]});
        check(hit, $sformatf("%s line %0d (oe,out)", e.tag, e.line), got, int'({1'b1, e.val}));
        busy = 1'b0;
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic expect_all(input int bound, input string tag);
    for (int i = 0; i < N; i++) begin
      if (DIR[i]) expect_out(1, i, a_pin_in[i], bound, tag);
      else        expect_out(0, i, b_pin_in[i], bound, tag);
    end
  endtask

  initial begin
    logic orig;
    bit   moved;
    rst_n = 1'b0; a_en = 1'b1; b_en = 1'b1;
    a_pin_in = 5'b00101; b_pin_in = 5'b11000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R4 / R5: reset levels and hold-off quiet
    repeat (5) @(negedge clk);
    check(a_pin_oe == '0 && b_pin_oe == '0, "R5 hold-off oe", int'({a_pin_oe, b_pin_oe}), 0);
    check(a_pin_out == '0 && b_pin_out == '0, "R4 reset latch level", int'({a_pin_out, b_pin_out}), 0);
    repeat (20) @(negedge clk);
    check(a_pin_oe == '0 && b_pin_oe == '0, "R5 late hold-off oe", int'({a_pin_oe, b_pin_oe}), 0);
    check(a_pin_out == '0 && b_pin_out == '0, "R4 no command yet", int'({a_pin_out, b_pin_out}), 0);

    // R5: all lines converge after hold-off
    expect_all(HOLDOFF + 30, "R5 post hold-off");
    settle();
    check((a_pin_oe & DIR) == '0 && (b_pin_oe & ~DIR) == '0, "R8 sender side undriven",
          int'({a_pin_oe & DIR, b_pin_oe & ~DIR}), 0);

    // R1: single edges each forward line, both polarities
    for (int i = 0; i < 3; i++) begin
      for (int p = 0; p < 2; p++) begin
        a_pin_in[i] = ~a_pin_in[i];
        expect_out(1, i, a_pin_in[i], EDGE_BND, "R1 edge");
        settle();
      end
    end
    // R8: reverse direction lines
    for (int i = 3; i < 5; i++) begin
      b_pin_in[i] = ~b_pin_in[i];
      expect_out(0, i, b_pin_in[i], EDGE_BND, "R8 reverse edge");
      settle();
    end

    // R3: simultaneous edges on all forward lines
    a_pin_in[2:0] = ~a_pin_in[2:0];
    for (int i = 0; i < 3; i++) expect_out(1, i, a_pin_in[i], EDGE_BND, "R3 burst");
    settle();

    // R9: narrow pulse dropped
    orig = a_pin_in[0];
    a_pin_in[0] = ~orig;
    repeat (MINP - 2) @(negedge clk);
    a_pin_in[0] = orig;
    moved = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (b_pin_out[0] != orig || !b_pin_oe[0]) moved = 1'b1;
    end
    check(!moved, "R9 narrow pulse dropped", int'(moved), 0);
    // R9: wide pulse carried
    a_pin_in[0] = ~orig;
    expect_out(1, 0, ~orig, EDGE_BND, "R9 wide pulse high");
    expect_out(1, 0, orig, EDGE_BND + 2 * MINP, "R9 wide pulse return");
    repeat (2 * MINP) @(negedge clk);
    a_pin_in[0] = orig;
    settle();

    // R6: side A disabled
    a_en = 1'b0;
    repeat (2) @(negedge clk);
    check(a_pin_oe == '0, "R6 A tri-stated", int'(a_pin_oe), 0);
    orig = a_pin_in[0];
    a_pin_in[0] = ~orig;
    moved = 1'b0;
    for (int c = 0; c < 2 * REFRESH + 20; c++) begin
      @(negedge clk);
      if (b_pin_out[0] != orig) moved = 1'b1;
    end
    check(!moved, "R6 frozen input not sent", int'(moved), 0);
    // R7: re-enable A
    a_en = 1'b1;
    expect_out(1, 0, ~orig, REEN_BND, "R7 A re-enable");
    expect_out(0, 3, b_pin_in[3], REEN_BND, "R7 A outputs back");
    expect_out(0, 4, b_pin_in[4], REEN_BND, "R7 A outputs back");
    settle();

    // R6/R7: side B disabled then re-enabled
    b_en = 1'b0;
    repeat (2) @(negedge clk);
    check(b_pin_oe == '0, "R6 B tri-stated", int'(b_pin_oe), 0);
    a_pin_in[1] = ~a_pin_in[1];
    repeat (20) @(negedge clk);
    check(b_pin_oe == '0, "R6 B still tri-stated", int'(b_pin_oe), 0);
    b_en = 1'b1;
    expect_all(REEN_BND, "R7 B re-enable");
    settle();

    // R2: corrupt line 1 latch through the channel, expect periodic repair
    @(negedge clk);
    force u_elink_top.ab_vld = 1'b1;
    force u_elink_top.ab_idx = 3'd1;
    force u_elink_top.ab_val = ~a_pin_in[1];
    @(negedge clk);
    release u_elink_top.ab_vld;
    release u_elink_top.ab_idx;
    release u_elink_top.ab_val;
    expect_out(1, 1, a_pin_in[1], REC_BND, "R2 refresh repair");
    settle();
    expect_all(REC_BND, "R2 all lines consistent");
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule